// File: doc/BRIEF.md
# Dual-Edge Multiplexed Converter Output Bus

This block puts two 16-bit sample streams on one 16-bit bus for a digital-to-analog converter. One stream carries the transmit samples and the other carries the analog echo-cancellation samples. A qualifying clock goes out with the bus. The echo word is on the bus while that clock is high, so the converter captures it on the falling edge. The transmit word is on the bus while the clock is low, so it is captured on the rising edge. In each qualifying-clock period the bus therefore shows the echo word first and then the transmit word of the same pair.

The block runs from one master clock (35.328 MHz in the target system). It divides that clock by 2, 4 or 16 to make the qualifying clock, giving per-stream rates of 17.664, 8.832 and 2.208 MS/s. Both streams always use the same rate. Each stream writes into a holding register whenever its valid strobe is high. A word pair is taken from the holding registers only at the start of a qualifying-clock period. The rate select and the number-format select are also taken only at that point, so a pair never mixes rates or formats. The output is offset binary by default, made by inverting the sign bit of the twos-complement sample. A format select passes the twos-complement value through unchanged instead.

Top module: `dac_mux_bus`

## Requirements
- R1: During reset and straight after it, `dac_qclk` is 1 and `dac_bus` is 16'h8000. This is the offset-binary form of a zero echo sample at the fastest rate.
- R2: Within every qualifying-clock period, the bus holds the echo word of a pair while `dac_qclk` is high. It holds the transmit word of the same pair while `dac_qclk` is low, up to the next rising edge.
- R3: With `rate_sel` = 2'b00, the `dac_qclk` period is 2 master cycles: 1 high and 1 low.
- R4: With `rate_sel` = 2'b01, the `dac_qclk` period is 4 master cycles: 2 high and 2 low.
- R5: With `rate_sel` = 2'b10 or 2'b11, the `dac_qclk` period is 16 master cycles: 8 high and 8 low.
- R6: `rate_sel` and `twos_sel` are sampled only on the last master cycle of a qualifying-clock period. A new value applies from the following period onward, for both words of a pair.
- R7: With `twos_sel` = 0, each bus word is the sample with bit 15 inverted. With `twos_sel` = 1, the sample is passed through unchanged.
- R8: A sample is captured only on a master edge where its valid strobe is 1. The pair shown in a period is the most recent capture made before the edge that starts that period. Without a strobe, the old sample is repeated.
- R9: `dac_bus` changes only on master edges where `dac_qclk` also changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 16 | Transmit sample, twos complement |
| tx_valid | input | 1 | Transmit sample strobe |
| aec_data | input | 16 | Echo-cancellation sample, twos complement |
| aec_valid | input | 1 | Echo sample strobe |
| rate_sel | input | 2 | 00 full, 01 half, 10/11 slow rate |
| twos_sel | input | 1 | 1 selects twos-complement output |
| dac_bus | output | 16 | Multiplexed converter data |
| dac_qclk | output | 1 | Qualifying clock |

## Verification
The hardest case to reach is a rate or format change that arrives part way through a period, most of all a change from the slow rate to the fast one. The old period has to finish at its own length before the new rate takes over. To reach this, the bench changes `rate_sel`, `twos_sel` and the data at random master cycles, with the strobes switched on and off at random. A cycle-accurate behavioural model is compared with the bus on every cycle. Separate settled segments measure each period length and check which stream sits on which edge.

// File: rtl/dac_mux_pkg.sv
package dac_mux_pkg;
  typedef enum logic [1:0] {
    RATE_FULL = 2'b00,
    RATE_HALF = 2'b01,
    RATE_SLOW = 2'b10,
    RATE_SLOW_ALT = 2'b11
  } rate_e;
endpackage

// File: rtl/dac_rate_ctrl.sv
module dac_rate_ctrl
  import dac_mux_pkg::*;
#(
  parameter int DIV_FULL = 2,
  parameter int DIV_HALF = 4,
  parameter int DIV_SLOW = 16,
  localparam int CW = $clog2(DIV_SLOW)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_in,
  input  logic       fmt_in,
  output logic       qclk,
  output logic       pair_load,
  output logic       fmt_q
);
  localparam logic [CW-1:0] FULL_LAST = CW'(DIV_FULL - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(DIV_HALF - 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'(DIV_SLOW - 1);
  localparam logic [CW-1:0] FULL_MID  = CW'(DIV_FULL / 2);
  localparam logic [CW-1:0] HALF_MID  = CW'(DIV_HALF / 2);
  localparam logic [CW-1:0] SLOW_MID  = CW'(DIV_SLOW / 2);

  rate_e         rate_q, rate_d;
  logic [CW-1:0] cnt_q, cnt_d, last_cnt, mid_cnt;
  logic          fmt_d;

  always_comb begin
    case (rate_q)
      RATE_FULL: begin last_cnt = FULL_LAST; mid_cnt = FULL_MID; end
      RATE_HALF: begin last_cnt = HALF_LAST; mid_cnt = HALF_MID; end
      default:   begin last_cnt = SLOW_LAST; mid_cnt = SLOW_MID; end
    endcase
  end

  always_comb begin
    pair_load = (cnt_q == last_cnt);
    cnt_d     = pair_load ? '0 : cnt_q + 1'b1;
    rate_d    = pair_load ? rate_e'(rate_in) : rate_q;
    fmt_d     = pair_load ? fmt_in : fmt_q;
    qclk      = (cnt_q < mid_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rate_q <= RATE_FULL;
      fmt_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rate_q <= rate_d;
      fmt_q  <= fmt_d;
    end
  end

  // R6
  setting_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_load |=> ($stable(rate_q) && $stable(fmt_q)));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_cnt);

  // R2
  rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qclk) |-> (cnt_q == '0));
endmodule

// File: rtl/dac_pair_store.sv
module dac_pair_store #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] tx_in,
  input  logic          tx_stb,
  input  logic [DW-1:0] aec_in,
  input  logic          aec_stb,
  input  logic          load,
  output logic [DW-1:0] tx_word,
  output logic [DW-1:0] aec_word
);
  logic [DW-1:0] tx_hold_q, tx_hold_d, aec_hold_q, aec_hold_d;
  logic [DW-1:0] tx_word_d, aec_word_d;

  always_comb begin
    tx_hold_d  = tx_stb  ? tx_in  : tx_hold_q;
    aec_hold_d = aec_stb ? aec_in : aec_hold_q;
    tx_word_d  = load ? tx_hold_q  : tx_word;
    aec_word_d = load ? aec_hold_q : aec_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold_q  <= '0;
      aec_hold_q <= '0;
      tx_word    <= '0;
      aec_word   <= '0;
    end else begin
      tx_hold_q  <= tx_hold_d;
      aec_hold_q <= aec_hold_d;
      tx_word    <= tx_word_d;
      aec_word   <= aec_word_d;
    end
  end

  // R8
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(tx_word) && $stable(aec_word)));
endmodule

// File: rtl/dac_edge_mux.sv
module dac_edge_mux #(
  parameter int DW = 16
) (
  input  logic          phase_hi,
  input  logic          twos,
  input  logic [DW-1:0] tx_word,
  input  logic [DW-1:0] aec_word,
  output logic [DW-1:0] bus
);
  logic [DW-1:0] picked;

  always_comb begin
    picked = phase_hi ? aec_word : tx_word;
    bus    = twos ? picked : {~picked[DW-1], picked[DW-2:0]};
  end
endmodule

// File: rtl/dac_mux_bus.sv
module dac_mux_bus #(
  parameter int DW       = 16,
  parameter int DIV_FULL = 2,
  parameter int DIV_HALF = 4,
  parameter int DIV_SLOW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  input  logic [DW-1:0] aec_data,
  input  logic          aec_valid,
  input  logic [1:0]    rate_sel,
  input  logic          twos_sel,
  output logic [DW-1:0] dac_bus,
  output logic          dac_qclk
);
  logic          load;
  logic          fmt_cur;
  logic [DW-1:0] tx_w, aec_w;

  dac_rate_ctrl #(
    .DIV_FULL(DIV_FULL), .DIV_HALF(DIV_HALF), .DIV_SLOW(DIV_SLOW)
  ) u_rate (
    .clk(clk), .rst_n(rst_n), .rate_in(rate_sel), .fmt_in(twos_sel),
    .qclk(dac_qclk), .pair_load(load), .fmt_q(fmt_cur)
  );

  dac_pair_store #(.DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .tx_in(tx_data), .tx_stb(tx_valid),
    .aec_in(aec_data), .aec_stb(aec_valid), .load(load),
    .tx_word(tx_w), .aec_word(aec_w)
  );

  dac_edge_mux #(.DW(DW)) u_mux (
    .phase_hi(dac_qclk), .twos(fmt_cur), .tx_word(tx_w),
    .aec_word(aec_w), .bus(dac_bus)
  );

  // R9
  bus_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(dac_qclk) |-> $stable(dac_bus));

  // R2
  rise_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> dac_qclk);
endmodule

// File: tb/dac_mux_bus_test.sv
module dac_mux_bus_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tx_data = '0, aec_data = '0;
  logic        tx_valid = 1'b0, aec_valid = 1'b0;
  logic [1:0]  rate_sel = 2'b00;
  logic        twos_sel = 1'b0;
  logic [15:0] dac_bus;
  logic        dac_qclk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  dac_mux_bus uut (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .aec_data(aec_data), .aec_valid(aec_valid), .rate_sel(rate_sel),
    .twos_sel(twos_sel), .dac_bus(dac_bus), .dac_qclk(dac_qclk)
  );

  function automatic logic [15:0] shape(logic [15:0] x, bit tw);
    return tw ? x : (x ^ 16'h8000);
  endfunction

  function automatic int period_of(logic [1:0] r);
    return (r == 2'b00) ? 2 : (r == 2'b01) ? 4 : 16;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int          m_ph = 0, m_per = 2;
  bit          m_fmt = 0;
  logic [15:0] m_ptx = '0, m_paec = '0, m_htx = '0, m_haec = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_per = 2; m_fmt = 0;
      m_ptx = '0; m_paec = '0; m_htx = '0; m_haec = '0;
    end else begin
      if (m_ph == m_per - 1) begin
        m_ph = 0;
        m_per = period_of(rate_sel);
        m_fmt = twos_sel;
        m_ptx = m_htx;
        m_paec = m_haec;
      end else begin
        m_ph = m_ph + 1;
      end
      if (tx_valid) m_htx = tx_data;
      if (aec_valid) m_haec = aec_data;
    end
  end

  // directed-segment expectations
  bit          run_chk = 0, edge_en = 0, per_en = 0;
  string       edge_tag = "R2", per_tag = "R3";
  int          per_exp = 2;
  logic [15:0] seg_tx = '0, seg_aec = '0;
  bit          seg_fmt = 0;
  logic        prev_clk = 1'b1;
  logic [15:0] prev_bus = '0;
  int          since_rise = 0;

  always @(negedge clk) begin
    if (run_chk && !finished) begin
      bit exp_clk;
      exp_clk = (m_ph < m_per / 2);
      check("R6 R9 model qclk", {15'd0, dac_qclk}, {15'd0, exp_clk});
      check("R6 R9 model bus", dac_bus,
            shape(exp_clk ? m_paec : m_ptx, m_fmt));
      since_rise++;
      if (!prev_clk && dac_qclk) begin
        if (per_en) check(per_tag, 16'(since_rise), 16'(per_exp));
        if (edge_en) check({edge_tag, " tx at rise"}, prev_bus, shape(seg_tx, seg_fmt));
        since_rise = 0;
      end
      if (prev_clk && !dac_qclk && edge_en)
        check({edge_tag, " aec at fall"}, prev_bus, shape(seg_aec, seg_fmt));
      prev_clk = dac_qclk;
      prev_bus = dac_bus;
    end
  end

  task automatic segment(logic [1:0] r, bit tw, logic [15:0] t, logic [15:0] a,
                         bit v, logic [15:0] et, logic [15:0] ea,
                         string etag, string ptag);
    @(negedge clk);
    edge_en = 0; per_en = 0;
    rate_sel = r; twos_sel = tw; tx_data = t; aec_data = a;
    tx_valid = v; aec_valid = v;
    repeat (40) @(negedge clk);
    seg_tx = et; seg_aec = ea; seg_fmt = tw;
    per_exp = period_of(r); edge_tag = etag; per_tag = ptag;
    edge_en = 1; per_en = 1;
    repeat (70) @(negedge clk);
    edge_en = 0; per_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset qclk", {15'd0, dac_qclk}, 16'd1);
    check("R1 reset bus", dac_bus, 16'h8000);
    prev_clk = dac_qclk; prev_bus = dac_bus;
    run_chk = 1;

    segment(2'b00, 0, 16'h1234, 16'hABCD, 1, 16'h1234, 16'hABCD, "R2", "R3");
    segment(2'b01, 1, 16'h8001, 16'h7FFF, 1, 16'h8001, 16'h7FFF, "R7", "R4");
    segment(2'b10, 0, 16'h0000, 16'hFFFF, 1, 16'h0000, 16'hFFFF, "R7", "R5");
    segment(2'b11, 1, 16'h5A5A, 16'hC3C3, 1, 16'h5A5A, 16'hC3C3, "R2", "R5");
    // R8: strobes low, new data must not reach the bus
    segment(2'b01, 0, 16'h0F0F, 16'h1111, 0, 16'h5A5A, 16'hC3C3, "R8", "R4");

    // R6: settings and data changing at arbitrary cycles
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      tx_data = 16'($urandom); aec_data = 16'($urandom);
      tx_valid = 1'($urandom); aec_valid = 1'($urandom);
      if ((i % 7) == 3) rate_sel = 2'($urandom);
      if ((i % 13) == 5) twos_sel = 1'($urandom);
    end

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule